// File: doc/BRIEF.md
# Write-First Dual-Port Synchronous RAM

This block is a memory with two independent ports, A and B, on one clock. Each port has its own address, write data, write enable and registered read output. A single clock enable gates the whole block. When the enable is high, a port whose write enable is set stores its data. A port that is not writing reads. Read data appears on the port's output register one clock after the address is presented. The enable and both write enables are active high.

Reads return new data in both same-address cases. A port that writes shows the word it just wrote on its own output. A port that reads the address the other port is writing in the same cycle gets the incoming data rather than the old word. This comes from an address-compare bypass in front of each output register. The array itself has no read-during-write path.

Depth is 2**ADDR_W words of DATA_W bits, and the contents start at zero. If both ports write one address in the same cycle, the stored word and both outputs are left undefined. Callers must avoid that case.

Top module: `wf_tdp_ram`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, both read outputs are zero.
- R2: With `en` low, no write takes place on either port, and both read outputs keep their previous values.
- R3: With `en` high and a port's write enable low, that port's output shows the stored word at its address one clock later.
- R4: With `en` high and a port's write enable high, that port's output shows its own write data one clock later.
- R5: When one port reads an address that the other port writes in the same enabled cycle, the reading port's output shows the other port's write data one clock later.
- R6: Both ports may write different addresses in the same cycle, and both words are stored.
- R7: When both ports read the same address with no write, both outputs show the same stored word.
- R8: All 2**ADDR_W addresses hold independent words, and a write changes only its addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low reset of the read output registers |
| en | input | 1 | Clock enable, active high |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
An address sweep first writes every word through one port with a value derived from the address, then reads every word back through the other port. A wrong decode or a word that leaks into its neighbours shows up here. A cross sweep then puts one port writing and the other reading the same address, in both directions. This separates a working bypass from old-data reads. Paired writes to distinct addresses and paired reads of one address test the two ports acting together. Random traffic with stall cycles shows whether writes are blocked and outputs held while the enable is low. Each port's output is compared every cycle against a reference array in the bench.

// File: rtl/wf_tdp_pkg.sv
package wf_tdp_pkg;
   localparam int NUM_PORTS = 2;
   localparam int MAX_ADDR_W = 16;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } port_op_e;

   function automatic port_op_e decode_op(input logic en, input logic we);
      if (!en)      return OP_HOLD;
      else if (we)  return OP_WRITE;
      else          return OP_READ;
   endfunction
endpackage

// File: rtl/wf_tdp_store.sv
module wf_tdp_store
   import wf_tdp_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                             clk,
   input  logic                             en,
   input  logic [NUM_PORTS-1:0]             we,
   input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
   input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata,
   output logic [NUM_PORTS-1:0][DATA_W-1:0] word
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
   end

   // Port order sets which write lands last; a same-address collision is undefined.
   always_ff @(posedge clk) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (decode_op(en, we[p]) == OP_WRITE) mem[addr[p]] <= wdata[p];
      end
   end

   // Array read before this cycle's writes; the bypass stage supplies new data.
   always_comb begin
      for (int p = 0; p < NUM_PORTS; p++) word[p] = mem[addr[p]];
   end
endmodule

// File: rtl/wf_tdp_rdport.sv
module wf_tdp_rdport
   import wf_tdp_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              own_we,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [DATA_W-1:0] own_wdata,
   input  logic              peer_we,
   input  logic [ADDR_W-1:0] peer_addr,
   input  logic [DATA_W-1:0] peer_wdata,
   input  logic [DATA_W-1:0] array_word,
   output logic [DATA_W-1:0] rdata
);
   port_op_e          op;
   logic              peer_hit;
   logic [DATA_W-1:0] next_q;

   always_comb begin
      op       = decode_op(en, own_we);
      peer_hit = peer_we && (peer_addr == own_addr);
      unique case (op)
         OP_WRITE: next_q = own_wdata;
         OP_READ:  next_q = peer_hit ? peer_wdata : array_word;
         default:  next_q = rdata;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rdata <= '0;
      else if (op != OP_HOLD) rdata <= next_q;
   end
endmodule

// File: rtl/wf_tdp_ram.sv
module wf_tdp_ram
   import wf_tdp_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);
   if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr_w
      $error("wf_tdp_ram: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("wf_tdp_ram: DATA_W must be positive");
   end

   logic [NUM_PORTS-1:0]             we;
   logic [NUM_PORTS-1:0][ADDR_W-1:0] addr;
   logic [NUM_PORTS-1:0][DATA_W-1:0] wdata;
   logic [NUM_PORTS-1:0][DATA_W-1:0] word;
   logic [NUM_PORTS-1:0][DATA_W-1:0] rdata;

   assign we    = {b_we, a_we};
   assign addr  = {b_addr, a_addr};
   assign wdata = {b_wdata, a_wdata};
   assign a_rdata = rdata[0];
   assign b_rdata = rdata[1];

   wf_tdp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .en    (en),
      .we    (we),
      .addr  (addr),
      .wdata (wdata),
      .word  (word)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int PEER = NUM_PORTS - 1 - p;
      wf_tdp_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
         .clk        (clk),
         .rst_n      (rst_n),
         .en         (en),
         .own_we     (we[p]),
         .own_addr   (addr[p]),
         .own_wdata  (wdata[p]),
         .peer_we    (we[PEER]),
         .peer_addr  (addr[PEER]),
         .peer_wdata (wdata[PEER]),
         .array_word (word[p]),
         .rdata      (rdata[p])
      );
   end
endmodule

// File: rtl/wf_tdp_ram_chk.sv
module wf_tdp_ram_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              a_we,
   input logic [ADDR_W-1:0] a_addr,
   input logic [DATA_W-1:0] a_wdata,
   input logic [DATA_W-1:0] a_rdata,
   input logic              b_we,
   input logic [ADDR_W-1:0] b_addr,
   input logic [DATA_W-1:0] b_wdata,
   input logic [DATA_W-1:0] b_rdata
);
   wire same_addr = (a_addr == b_addr);

   a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(a_rdata) && $stable(b_rdata)));

   a_r4_a_own_write: assert property (@(posedge clk) disable iff (!rst_n)
      (en && a_we && !(b_we && same_addr)) |=> (a_rdata == $past(a_wdata)));

   a_r4_b_own_write: assert property (@(posedge clk) disable iff (!rst_n)
      (en && b_we && !(a_we && same_addr)) |=> (b_rdata == $past(b_wdata)));

   a_r5_a_sees_b: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !a_we && b_we && same_addr) |=> (a_rdata == $past(b_wdata)));

   a_r5_b_sees_a: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !b_we && a_we && same_addr) |=> (b_rdata == $past(a_wdata)));

   a_r7_same_read: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !a_we && !b_we && same_addr) |=> (a_rdata == b_rdata));
endmodule

bind wf_tdp_ram wf_tdp_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en),
   .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
   .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
);

// File: tb/wf_tdp_ram_tb.sv
module wf_tdp_ram_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          a_we = 1'b0, b_we = 1'b0;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic [DW-1:0] a_wdata = '0, b_wdata = '0;
   logic [DW-1:0] a_rdata, b_rdata;

   logic [DW-1:0] ref_mem [DEPTH];
   logic [DW-1:0] exp_a, exp_b;
   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wf_tdp_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
   );

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // One cycle: drive at the falling edge, model, then check at the next falling edge.
   task automatic step(input string req, input logic e,
                       input logic awe, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                       input logic bwe, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
      en = e; a_we = awe; a_addr = aa; a_wdata = ad;
      b_we = bwe; b_addr = ba; b_wdata = bd;
      if (e) begin
         exp_a = awe ? ad : ((bwe && ba == aa) ? bd : ref_mem[aa]);
         exp_b = bwe ? bd : ((awe && aa == ba) ? ad : ref_mem[ba]);
         if (awe) ref_mem[aa] = ad;
         if (bwe) ref_mem[ba] = bd;
      end
      @(posedge clk);
      @(negedge clk);
      check(req, "port A", a_rdata, exp_a);
      check(req, "port B", b_rdata, exp_b);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      exp_a = '0; exp_b = '0;
      repeat (3) @(negedge clk);
      check("R1", "reset A", a_rdata, '0);
      check("R1", "reset B", b_rdata, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "after release A", a_rdata, '0);
      check("R1", "after release B", b_rdata, '0);

      // R8/R4: fill every word through A, read back through B (R3)
      for (int i = 0; i < DEPTH; i++)
         step("R4", 1'b1, 1'b1, AW'(i), DW'(i * 7 + 3), 1'b0, AW'(DEPTH-1-i), '0);
      for (int i = 0; i < DEPTH; i++)
         step("R8", 1'b1, 1'b0, AW'(DEPTH-1-i), '0, 1'b0, AW'(i), '0);
      // R4 on B, then R3 reads on A
      for (int i = 0; i < DEPTH; i++)
         step("R4", 1'b1, 1'b0, AW'(i), '0, 1'b1, AW'(i+1), DW'(i * 13 + 90));
      for (int i = 0; i < DEPTH; i++)
         step("R3", 1'b1, 1'b0, AW'(i), '0, 1'b0, AW'(i+5), '0);
      // R5: cross-port write-first, both directions
      for (int i = 0; i < DEPTH; i++) begin
         step("R5", 1'b1, 1'b0, AW'(i), '0, 1'b1, AW'(i), DW'(8'hA0 ^ i));
         step("R5", 1'b1, 1'b1, AW'(i), DW'(8'h50 + i), 1'b0, AW'(i), '0);
      end
      // R6: simultaneous writes to distinct addresses, then readback
      for (int i = 0; i < DEPTH/2; i++)
         step("R6", 1'b1, 1'b1, AW'(2*i), DW'(8'hC0 + i), 1'b1, AW'(2*i+1), DW'(8'h30 + i));
      for (int i = 0; i < DEPTH/2; i++)
         step("R6", 1'b1, 1'b0, AW'(2*i), '0, 1'b0, AW'(2*i+1), '0);
      // R7: both ports read the same address
      for (int i = 0; i < DEPTH; i++)
         step("R7", 1'b1, 1'b0, AW'(i), '0, 1'b0, AW'(i), '0);
      // R2: stalls with writes requested, then readback of the touched words
      for (int i = 0; i < DEPTH; i++)
         step("R2", 1'b0, 1'b1, AW'(i), 8'hEE, 1'b1, AW'(i+8), 8'hDD);
      for (int i = 0; i < DEPTH; i++)
         step("R2", 1'b1, 1'b0, AW'(i), '0, 1'b0, AW'(i+3), '0);
      // Mixed random traffic with stalls; same-address double writes avoided
      for (int n = 0; n < 3000; n++) begin
         logic e, aw, bw;
         logic [AW-1:0] aa, ba;
         e  = ($urandom % 4) != 0;
         aw = $urandom % 2;
         bw = $urandom % 2;
         aa = AW'($urandom);
         ba = ($urandom % 3 == 0) ? aa : AW'($urandom);
         if (aw && bw && aa == ba) bw = 1'b0;
         step("R3", e, aw, aa, DW'($urandom), bw, ba, DW'($urandom));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule